// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a 32-bit countdown timer for a processor-local interrupt controller. Software writes a start value and the counter counts down to zero. A prescaler slows the count, so each decrement takes a power-of-two number of input clocks. When the count reaches zero the block gives a single-cycle expiry pulse and then stays idle until software loads a new value.

The register port has three registers. A divide register selects the prescale ratio with a three-bit code whose bits sit at positions 3, 1 and 0. A start register loads the counter and restarts it. A live-count register is read-only and returns the number of prescaled ticks still to run. Writes are captured on a rising clock edge. Read data is registered: the value seen after an edge reflects the state just before that edge.

Top module: `cdt_timer`

## Requirements
- R1: A write to address 0 keeps only bits 3, 1 and 0 of the write data. Reading address 0 returns those three bits in place, and every other bit reads as zero.
- R2: The prescale code is {bit3, bit1, bit0}. The divide ratio is 2 raised to ((code + 1) mod 8). Code 000 divides by 2, code 111 divides by 1 and code 110 divides by 128.
- R3: A write to address 1 takes the full 32-bit value, restarts both the count and the prescaler, and applies even while a countdown is running. Reading address 1 returns the last value written there.
- R4: When a start value N is captured at edge k with ratio R, the count reaches zero at edge k + N*R. The first decrement happens no earlier than the edge after the capture.
- R5: Reading address 2 returns the remaining prescaled ticks, rounded up. It returns 0 when the timer is idle. Reading address 3 returns 0. Read data after an edge shows the state that held before that edge.
- R6: Writes to address 2 have no effect on the count.
- R7: When the count reaches zero, `expire` is high for exactly one cycle. After that the timer stops and address 2 reads 0.
- R8: Writing a start value of 0 stops the timer, and no expiry pulse follows.
- R9: If the divide code changes during a countdown, the tick in progress finishes at the old ratio. The new ratio applies from the next prescaler wrap.
- R10: If a start-value write is captured on the same edge at which the count would reach zero, the write wins. No pulse is produced and the new countdown begins.
- R11: After reset the divide code is 000 (ratio 2), all registers read 0 and `expire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Registered read data |
| expire | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
Two events can land on the same edge: a new start value being captured, and the final decrement to zero. The bench follows a countdown until the cycle just before expiry and times a start-value write so that it is captured on the expiry edge. It then requires that no pulse appears and that the live count follows the new value. A divide-code write timed to land partway through a prescaled tick is judged by when the pulse arrives: one tick at the old ratio, then the remaining ticks at the new ratio.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned PRE_W = 7;   // widest prescale exponent is 7
  localparam int unsigned CODE_W = 3;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_INIT = 2'd1,
    REG_CUR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Terminal value of the prescale counter (ratio - 1) for a divide code.
  function automatic logic [PRE_W-1:0] div_limit(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] expo;
    logic [CODE_W-1:0] sh;
    expo = code + 3'd1;
    sh   = 3'(PRE_W) - expo;
    return {PRE_W{1'b1}} >> sh;
  endfunction
endpackage

// File: rtl/cdt_cfg_reg.sv
module cdt_cfg_reg
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [CODE_W-1:0]   code,
  output logic [DATA_W-1:0]   rb_val,
  output logic [PRE_W-1:0]    limit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else if (we) begin
      code <= {wdata[3], wdata[1:0]};
    end
  end

  always_comb begin
    rb_val    = '0;
    rb_val[3] = code[2];
    rb_val[1] = code[1];
    rb_val[0] = code[0];
    limit     = div_limit(code);
  end
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] cfg_limit,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] act_lim;
  logic             wrap;

  assign wrap = (pcnt == act_lim);
  assign tick = run && !restart && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      act_lim <= '0;
    end else if (restart) begin
      pcnt    <= '0;
      act_lim <= cfg_limit;
    end else if (run) begin
      if (wrap) begin
        pcnt    <= '0;
        act_lim <= cfg_limit;  // new ratio takes effect per wrap
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end else begin
      pcnt <= '0;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign running = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (tick && running) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) expire <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire
);
  logic              we_div;
  logic              we_init;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  div_rb;
  logic [PRE_W-1:0]  limit;
  logic              tick;
  logic              running;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  init_q;

  assign we_div  = wr_en && (wr_addr == REG_DIV);
  assign we_init = wr_en && (wr_addr == REG_INIT);

  cdt_cfg_reg #(.DATA_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (we_div),
    .wdata  (wr_data),
    .code   (code),
    .rb_val (div_rb),
    .limit  (limit)
  );

  cdt_prescaler u_pre (
    .clk       (clk),
    .rst       (rst),
    .restart   (we_init),
    .run       (running),
    .cfg_limit (limit),
    .tick      (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (we_init),
    .load_val (wr_data),
    .tick     (tick),
    .cnt      (cnt_q),
    .running  (running),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
    end else if (we_init) begin
      init_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_DIV:  rd_data <= div_rb;
        REG_INIT: rd_data <= init_q;
        REG_CUR:  rd_data <= cnt_q;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [1:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_q
);
  logic ld;
  assign ld = wr_en && (wr_addr == 2'd1);

  AST_CFG_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == 2'd0) |=> (rd_data[CNT_W-1:4] == '0 && !rd_data[2])); // R1

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(wr_data))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire); // R7

  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire |-> (cnt_q == '0)); // R7

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ld && wr_data == '0) |=> (!expire && cnt_q == '0)); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld |=> !expire); // R10
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .expire  (expire),
  .cnt_q   (cnt_q)
);

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        expire;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cdt_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .expire(expire)
  );

  function automatic int ratio_of(input int code);
    return 1 << ((code + 1) % 8);
  endfunction

  function automatic logic [31:0] cfg_word(input int code);
    return {28'hABCDE12, code[2], 1'b1, code[1:0]};  // junk bits must drop
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  // j = edges since the capture edge of the start value; rd_addr holds 2.
  task automatic step_check(input int n, input int r, input int j, input string req);
    int e;
    longint expc;
    e = j - 1;
    expc = (e >= n * r) ? 0 : n - e / r;
    check(rd_data == 32'(expc), req, rd_data, expc);
    check(expire == (j == n * r), req, expire, (j == n * r));
  endtask

  task automatic track(input int n, input int r, input int j0, input int j1, input string req);
    for (int j = j0; j <= j1; j++) begin
      cyc();
      step_check(n, r, j, req);
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); cyc();
      check(rd_data == 0, "R11", rd_data, 0);
      check(expire == 1'b0, "R11", expire, 0);
    end

    // R11/R4 default ratio 2
    rd_addr = 2'd2;
    wr(2'd1, 32'd3);
    track(3, 2, 1, 8, "R11");

    // R1 divide register mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd_addr = 2'd0; cyc();
    check(rd_data == 32'hB, "R1", rd_data, 32'hB);
    rd_addr = 2'd3; cyc();
    check(rd_data == 0, "R5", rd_data, 0);

    // R2 every code, N=2
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, cfg_word(c));
      rd_addr = 2'd2;
      wr(2'd1, 32'd2);
      track(2, ratio_of(c), 1, 2 * ratio_of(c) + 2, "R2");
    end

    // R3 restart mid count, plus readback of start register
    wr(2'd0, cfg_word(1));
    wr(2'd1, 32'd10);
    track(10, 4, 1, 13, "R3");
    wr(2'd1, 32'd2);
    track(2, 4, 1, 10, "R3");
    rd_addr = 2'd1; cyc();
    check(rd_data == 32'd2, "R3", rd_data, 2);

    // R6 write to live-count register ignored
    rd_addr = 2'd2;
    wr(2'd0, cfg_word(7));
    wr(2'd1, 32'd6);
    track(6, 1, 1, 2, "R6");
    wr(2'd2, 32'd1000);
    step_check(6, 1, 3, "R6");
    wr(2'd2, 32'd0);
    step_check(6, 1, 4, "R6");
    track(6, 1, 5, 9, "R6");

    // R3/R8 full-width load then stop with zero
    wr(2'd1, 32'hFFFF_FFFF);
    cyc();
    check(rd_data == 32'hFFFF_FFFF, "R3", rd_data, 32'hFFFF_FFFF);
    wr(2'd1, 32'd0);
    for (int j = 1; j <= 20; j++) begin
      cyc();
      check(expire == 1'b0, "R8", expire, 0);
      if (j > 1) check(rd_data == 0, "R8", rd_data, 0);
    end

    // R9 ratio change lands mid tick: one tick at 2, rest at 1
    wr(2'd0, cfg_word(0));
    wr(2'd1, 32'd4);
    wr(2'd0, cfg_word(7));          // captured at j=1
    for (int j = 2; j <= 7; j++) begin
      cyc();
      check(expire == (j == 5), "R9", expire, (j == 5));
      if (j == 4) check(rd_data == 32'd2, "R9", rd_data, 2);
      if (j == 7) check(rd_data == 32'd0, "R9", rd_data, 0);
    end

    // R10 reload captured on the expiry edge
    wr(2'd1, 32'd5);
    track(5, 1, 1, 4, "R10");
    wr(2'd1, 32'd3);
    check(expire == 1'b0, "R10", expire, 0);
    track(3, 1, 1, 6, "R10");

    // R4/R5/R7 random codes and counts
    for (int it = 0; it < 12; it++) begin
      int c;
      int n;
      c = int'($urandom % 8);
      n = 1 + int'($urandom % 6);
      wr(2'd0, cfg_word(c));
      wr(2'd1, 32'(n));
      track(n, ratio_of(c), 1, n * ratio_of(c) + 3, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule